// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

This block is one general-purpose I/O port of up to 32 pins, controlled by software through a simple synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. For each pin the port holds a direction bit, an output value, a pull-up enable and two alternate-function select bits. These drive the pad-side outputs directly. Pad inputs pass through a two-flop synchroniser before software reads them or the trigger logic uses them.

Each pin can raise an interrupt. The trigger is chosen by a 3-bit mode, built from three per-pin configuration registers: trigger-A is mode bit 0, trigger-B is mode bit 1 and level-select is mode bit 2. Detected events set a per-pin pending bit. The port combines the pending bits with the per-pin enables into a single registered request line for the interrupt controller above it.

Software changes the enables only through separate set and clear addresses, so it never needs a read-modify-write. The number of implemented pins is the parameter `NPINS`.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, every pad output and pad output-enable is 0, and `irq` is 0.
- R2: The registers at address 0x0 (direction, 1 = output), 0x1 (output value), 0x3 (pull-up), 0x4 (select 0) and 0x5 (select 1) are read/write. Each one appears bit for bit on `pad_oe`, `pad_out`, `pad_pullup`, `pad_sel0` and `pad_sel1` respectively.
- R3: Address 0x2 returns the pad input after two synchronising flops. A pad change sampled at clock edge k is readable after edge k+1. Writes to 0x2 have no effect.
- R4: A write to 0x9 sets the enable of each pin whose data bit is 1. A write to 0xA clears the enable of each pin whose data bit is 1. Zero bits leave the enable unchanged. The enables read back at 0xB. Reads of 0x9 and 0xA return 0.
- R5: The mode is {0x8 bit, 0x7 bit, 0x6 bit}. Mode 1 triggers on a synchronised rising edge, mode 2 on a falling edge and mode 3 on either edge. A pad change sampled at edge k shows as a pending bit (address 0xC) after edge k+2.
- R6: Mode 5 triggers on a high synchronised level and mode 6 on a low level. While the level is present, the pending bit stays set, even across a clear write.
- R7: Modes 0, 4 and 7 never set a pending bit.
- R8: Pending bits are sticky. Writing 1 to a bit of 0xC clears it, unless an event occurs in the same cycle. Zero bits have no effect.
- R9: `irq` is registered. It equals the OR over pins of (pending AND enable) as it stood one clock earlier.
- R10: Register bits at or above `NPINS` read as 0 and ignore writes.
- R11: A pending bit sets whether or not its pin is enabled. A disabled pending pin does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS | Raw pad input values |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_pullup | output | NPINS | Pad pull-up enables |
| pad_sel0 | output | NPINS | Alternate-function select bit 0 |
| pad_sel1 | output | NPINS | Alternate-function select bit 1 |
| irq | output | 1 | Combined interrupt request |

## Verification
Assertions check four behaviours on every cycle:
- the set and clear writes reach the enables;
- pending bits never drop without a clear;
- reserved and off modes never raise a pending bit;
- `irq` tracks the previous cycle's enabled pending bits and the upper read bits stay zero.

The bench's scenarios are needed for the rest. These cover:
- the exact latency from pad change to input read, to pending bit and to `irq`;
- the choice of edge polarity per mode;
- a level holding its pending bit against a clear write;
- a disabled pin keeping its pending bit without raising `irq`.

A behavioural reference model, fed from a history queue of pad samples, is compared with every output on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR    = 4'h0,
    RA_DOUT   = 4'h1,
    RA_DIN    = 4'h2,
    RA_PULL   = 4'h3,
    RA_SEL0   = 4'h4,
    RA_SEL1   = 4'h5,
    RA_TRIGA  = 4'h6,
    RA_TRIGB  = 4'h7,
    RA_LVL    = 4'h8,
    RA_ENSET  = 4'h9,
    RA_ENCLR  = 4'hA,
    RA_ENSTAT = 4'hB,
    RA_PEND   = 4'hC
  } reg_sel_e;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_BOTH = 3'd3,
    TRIG_RSV4 = 3'd4,
    TRIG_HIGH = 3'd5,
    TRIG_LOW  = 3'd6,
    TRIG_RSV7 = 3'd7
  } trig_e;
endpackage

// File: rtl/gpio_pin_event.sv
module gpio_pin_event
  import gpio_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pad_raw,
  input  trig_e mode,
  output logic  sync_o,
  output logic  event_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pad_raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  logic rise, fall;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

  always_comb begin
    unique case (mode)
      TRIG_RISE: event_o = rise;
      TRIG_FALL: event_o = fall;
      TRIG_BOTH: event_o = rise | fall;
      TRIG_HIGH: event_o = sync_q;
      TRIG_LOW:  event_o = ~sync_q;
      default:   event_o = 1'b0;
    endcase
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  sync_in,
  input  logic [NPINS-1:0]  pend_in,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  dout_o,
  output logic [NPINS-1:0]  pull_o,
  output logic [NPINS-1:0]  sel0_o,
  output logic [NPINS-1:0]  sel1_o,
  output logic [NPINS-1:0]  trga_o,
  output logic [NPINS-1:0]  trgb_o,
  output logic [NPINS-1:0]  lvl_o,
  output logic [NPINS-1:0]  en_o,
  output logic [NPINS-1:0]  pend_clr_o
);
  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] dir_q, dout_q, pull_q, sel0_q, sel1_q, trga_q, trgb_q, lvl_q, en_q;
  logic [NPINS-1:0] dir_d, dout_d, pull_d, sel0_d, sel1_d, trga_d, trgb_d, lvl_d, en_d;
  reg_sel_e sel;

  assign wd  = bus_wdata[NPINS-1:0];
  assign sel = reg_sel_e'(bus_addr);

  always_comb begin
    dir_d  = dir_q;
    dout_d = dout_q;
    pull_d = pull_q;
    sel0_d = sel0_q;
    sel1_d = sel1_q;
    trga_d = trga_q;
    trgb_d = trgb_q;
    lvl_d  = lvl_q;
    en_d   = en_q;
    pend_clr_o = '0;
    if (bus_we) begin
      unique case (sel)
        RA_DIR:   dir_d  = wd;
        RA_DOUT:  dout_d = wd;
        RA_PULL:  pull_d = wd;
        RA_SEL0:  sel0_d = wd;
        RA_SEL1:  sel1_d = wd;
        RA_TRIGA: trga_d = wd;
        RA_TRIGB: trgb_d = wd;
        RA_LVL:   lvl_d  = wd;
        RA_ENSET: en_d   = en_q | wd;
        RA_ENCLR: en_d   = en_q & ~wd;
        RA_PEND:  pend_clr_o = wd;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      pull_q <= '0;
      sel0_q <= '0;
      sel1_q <= '0;
      trga_q <= '0;
      trgb_q <= '0;
      lvl_q  <= '0;
      en_q   <= '0;
    end else begin
      dir_q  <= dir_d;
      dout_q <= dout_d;
      pull_q <= pull_d;
      sel0_q <= sel0_d;
      sel1_q <= sel1_d;
      trga_q <= trga_d;
      trgb_q <= trgb_d;
      lvl_q  <= lvl_d;
      en_q   <= en_d;
    end
  end

  logic [NPINS-1:0] rsel;
  always_comb begin
    unique case (sel)
      RA_DIR:    rsel = dir_q;
      RA_DOUT:   rsel = dout_q;
      RA_DIN:    rsel = sync_in;
      RA_PULL:   rsel = pull_q;
      RA_SEL0:   rsel = sel0_q;
      RA_SEL1:   rsel = sel1_q;
      RA_TRIGA:  rsel = trga_q;
      RA_TRIGB:  rsel = trgb_q;
      RA_LVL:    rsel = lvl_q;
      RA_ENSTAT: rsel = en_q;
      RA_PEND:   rsel = pend_in;
      default:   rsel = '0;
    endcase
    bus_rdata = '0;
    bus_rdata[NPINS-1:0] = rsel;
  end

  assign dir_o  = dir_q;
  assign dout_o = dout_q;
  assign pull_o = pull_q;
  assign sel0_o = sel0_q;
  assign sel1_o = sel1_q;
  assign trga_o = trga_q;
  assign trgb_o = trgb_q;
  assign lvl_o  = lvl_q;
  assign en_o   = en_q;

  // R4: set and clear strobes reach the enable register on the next edge
  a_r4_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RA_ENSET) |=> ((en_o & $past(wd)) == $past(wd)));
  a_r4_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RA_ENCLR) |=> ((en_o & $past(wd)) == '0));

  generate
    if (NPINS < BUS_W) begin : g_upper
      // R10: unimplemented bits always read zero
      a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:NPINS] == '0);
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_pend.sv
module gpio_irq_pend #(
  parameter int NPINS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] event_in,
  input  logic [NPINS-1:0] clr_in,
  input  logic [NPINS-1:0] en_in,
  output logic [NPINS-1:0] pend_o,
  output logic             irq_o
);
  logic [NPINS-1:0] pend_q, pend_d;
  logic             irq_q, irq_d;

  always_comb begin
    pend_d = (pend_q & ~clr_in) | event_in;
    irq_d  = |(pend_q & en_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_chk
      // R8: a pending bit only drops after a clear strobe
      a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[i] && !clr_in[i]) |=> pend_q[i]);
    end
  endgenerate

  // R9: request line follows the enabled pending set one cycle later
  a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_q & en_in)) |=> irq_o);
  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_q & en_in)) |=> !irq_o);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pullup,
  output logic [NPINS-1:0]  pad_sel0,
  output logic [NPINS-1:0]  pad_sel1,
  output logic              irq
);
  logic [NPINS-1:0] sync_v, event_v, pend_v, clr_v, en_v;
  logic [NPINS-1:0] trga_v, trgb_v, lvl_v;

  gpio_regs #(.NPINS(NPINS)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_in(sync_v), .pend_in(pend_v),
    .dir_o(pad_oe), .dout_o(pad_out), .pull_o(pad_pullup),
    .sel0_o(pad_sel0), .sel1_o(pad_sel1),
    .trga_o(trga_v), .trgb_o(trgb_v), .lvl_o(lvl_v),
    .en_o(en_v), .pend_clr_o(clr_v)
  );

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      trig_e mode_p;
      assign mode_p = trig_e'({lvl_v[p], trgb_v[p], trga_v[p]});

      gpio_pin_event evt_i (
        .clk(clk), .rst_n(rst_n), .pad_raw(pad_in[p]), .mode(mode_p),
        .sync_o(sync_v[p]), .event_o(event_v[p])
      );

      // R7: off and reserved modes keep a clear pending bit clear
      a_r7_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_p == TRIG_OFF || mode_p == TRIG_RSV4 || mode_p == TRIG_RSV7) && !pend_v[p])
          |=> !pend_v[p]);
    end
  endgenerate

  gpio_irq_pend #(.NPINS(NPINS)) pend_i (
    .clk(clk), .rst_n(rst_n),
    .event_in(event_v), .clr_in(clr_v), .en_in(en_v),
    .pend_o(pend_v), .irq_o(irq)
  );
endmodule

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
  localparam int NP = 20;
  localparam logic [31:0] MSK = 32'((64'd1 << NP) - 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] bus_addr;
  logic bus_we;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe, pad_pullup, pad_sel0, pad_sel1;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup),
    .pad_sel0(pad_sel0), .pad_sel1(pad_sel1), .irq(irq)
  );

  // Behavioural reference model
  bit [31:0] m_dir, m_out, m_pu, m_s0, m_s1, m_ta, m_tb, m_lv, m_en, m_pend;
  bit m_irq;
  bit [31:0] hist[$];

  function automatic bit [31:0] hist_at(int back);
    if (hist.size() >= back) return hist[hist.size() - back];
    return 32'h0;
  endfunction

  function automatic bit [31:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return m_dir;  4'h1: return m_out;  4'h2: return hist_at(2);
      4'h3: return m_pu;   4'h4: return m_s0;   4'h5: return m_s1;
      4'h6: return m_ta;   4'h7: return m_tb;   4'h8: return m_lv;
      4'hB: return m_en;   4'hC: return m_pend;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_dir, m_out, m_pu, m_s0, m_s1, m_ta, m_tb, m_lv, m_en, m_pend} = '0;
      m_irq = 0;
      hist.delete();
    end else begin
      bit [31:0] cur, old, ev, clr, wd;
      cur = hist_at(2);
      old = hist_at(3);
      ev = 0;
      for (int p = 0; p < NP; p++) begin
        int md;
        md = m_lv[p] * 4 + m_tb[p] * 2 + m_ta[p];
        if (md == 1 || md == 3) ev[p] = ev[p] | (cur[p] && !old[p]);
        if (md == 2 || md == 3) ev[p] = ev[p] | (!cur[p] && old[p]);
        if (md == 5) ev[p] = cur[p];
        if (md == 6) ev[p] = !cur[p];
      end
      wd = bus_wdata & MSK;
      clr = (bus_we && bus_addr == 4'hC) ? wd : 32'h0;
      m_irq = (m_pend & m_en) != 0;
      m_pend = (m_pend & ~clr) | ev;
      if (bus_we) begin
        case (bus_addr)
          4'h0: m_dir = wd;  4'h1: m_out = wd;  4'h3: m_pu = wd;
          4'h4: m_s0 = wd;   4'h5: m_s1 = wd;   4'h6: m_ta = wd;
          4'h7: m_tb = wd;   4'h8: m_lv = wd;
          4'h9: m_en = m_en | wd;
          4'hA: m_en = m_en & ~wd;
          default: ;
        endcase
      end
      hist.push_back(32'(pad_in));
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R2/R3 model rdata", bus_rdata, m_read(bus_addr));
      check("R9 model irq", 32'(irq), 32'(m_irq));
      check("R2 model pad_oe", 32'(pad_oe), m_dir);
      check("R2 model pad_out", 32'(pad_out), m_out);
      check("R2 model pad_pullup", 32'(pad_pullup), m_pu);
      check("R2 model pad_sel0", 32'(pad_sel0), m_s0);
      check("R2 model pad_sel1", 32'(pad_sel1), m_s1);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; pad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 13; a++) rd(4'(a), 32'h0, "R1 reset register");
    check("R1 reset irq", 32'(irq), 32'h0);
    check("R1 reset pad_oe", 32'(pad_oe), 32'h0);

    // R2 pad-control registers
    wr(4'h0, 32'hF0); wr(4'h1, 32'hA0); wr(4'h3, 32'h300);
    wr(4'h4, 32'h1);  wr(4'h5, 32'hC0000);
    rd(4'h0, 32'hF0, "R2 direction readback");
    rd(4'h5, 32'hC0000, "R2 select1 readback");
    check("R2 pad_oe", 32'(pad_oe), 32'hF0);
    check("R2 pad_out", 32'(pad_out), 32'hA0);
    check("R2 pad_pullup", 32'(pad_pullup), 32'h300);

    // R10 upper bits
    wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h1, MSK, "R10 upper bits read zero");
    wr(4'h1, 32'hA0);

    // R3 input synchroniser latency
    @(negedge clk); pad_in = 20'h12345;
    @(posedge clk); rd(4'h2, 32'h0, "R3 input not yet visible");
    @(posedge clk); rd(4'h2, 32'h12345, "R3 input after two flops");
    wr(4'h2, 32'hFFFFF);
    rd(4'h2, 32'h12345, "R3 write to input ignored");
    @(negedge clk); pad_in = '0;
    idle(4);
    rd(4'hC, 32'h0, "R7 mode 0 sets no pending");

    // R4 enable set/clear
    wr(4'h9, 32'h5); rd(4'hB, 32'h5, "R4 enable set");
    wr(4'h9, 32'h2); rd(4'hB, 32'h7, "R4 set keeps others");
    wr(4'hA, 32'h4); rd(4'hB, 32'h3, "R4 enable clear");
    wr(4'hA, 32'h0); rd(4'hB, 32'h3, "R4 zero clear no effect");
    rd(4'h9, 32'h0, "R4 set address reads zero");
    rd(4'hA, 32'h0, "R4 clear address reads zero");

    // R5 rising edge on pin 0, timing of pending and irq
    wr(4'h6, 32'h1);
    @(negedge clk); pad_in[0] = 1'b1;
    @(posedge clk); rd(4'hC, 32'h0, "R5 pending not after k");
    @(posedge clk); rd(4'hC, 32'h0, "R5 pending not after k+1");
    @(posedge clk); rd(4'hC, 32'h1, "R5 pending after k+2");
    check("R9 irq not yet", 32'(irq), 32'h0);
    @(posedge clk); rd(4'hC, 32'h1, "R8 pending holds");
    check("R9 irq one cycle later", 32'(irq), 32'h1);
    wr(4'hC, 32'h0); rd(4'hC, 32'h1, "R8 zero write no effect");
    wr(4'hC, 32'h1); rd(4'hC, 32'h0, "R8 write one clears");
    idle(1);
    check("R9 irq drops after clear", 32'(irq), 32'h0);
    @(negedge clk); pad_in[0] = 1'b0;
    idle(4);
    rd(4'hC, 32'h0, "R5 mode 1 ignores falling edge");

    // R5 falling and both edges; R11 disabled pin
    wr(4'h6, 32'h5); wr(4'h7, 32'h6);
    @(negedge clk); pad_in = 20'h6;
    idle(4);
    rd(4'hC, 32'h4, "R5 rise: mode 3 yes, mode 2 no");
    check("R11 disabled pending gives no irq", 32'(irq), 32'h0);
    @(negedge clk); pad_in = 20'h0;
    idle(4);
    rd(4'hC, 32'h6, "R5 fall: modes 2 and 3");
    check("R9 enabled pending raises irq", 32'(irq), 32'h1);
    wr(4'hC, 32'h6); rd(4'hC, 32'h0, "R8 clear two bits");

    // R6 level modes: pin3 high (5), pin4 low (6)
    wr(4'h6, 32'h0D); wr(4'h7, 32'h16); wr(4'h8, 32'h18);
    idle(3);
    rd(4'hC, 32'h10, "R6 low level pending");
    @(negedge clk); pad_in = 20'h8;
    idle(4);
    rd(4'hC, 32'h18, "R6 high level pending");
    wr(4'hC, 32'h18);
    rd(4'hC, 32'h18, "R6 clear ignored while level present");
    @(negedge clk); pad_in = 20'h10;
    idle(4);
    rd(4'hC, 32'h18, "R6 pending sticky after level leaves");
    wr(4'hC, 32'h18); rd(4'hC, 32'h0, "R6 clear after level gone");

    // R7 reserved modes 4 (pin5) and 7 (pin6)
    wr(4'h6, 32'h4D); wr(4'h7, 32'h56); wr(4'h8, 32'h78);
    @(negedge clk); pad_in = 20'h70;
    idle(4);
    rd(4'hC, 32'h0, "R7 modes 4 and 7 ignore rise");
    @(negedge clk); pad_in = 20'h10;
    idle(4);
    rd(4'hC, 32'h0, "R7 modes 4 and 7 ignore fall");

    idle(2);
    finish_run();
  end
endmodule